// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a key made of a process ID and a virtual page number into a physical frame. One table serves every resident process, and it holds one slot per physical frame. Each slot records the process and the virtual page that own that frame, plus a link to the next slot in its chain. The frame number is not stored in the slot: it is the slot's own index. Every key is folded to a short hash, and the hash selects a slot in a separate anchor table. Each anchor slot holds the head of a linked chain of frame slots. A chain ends at a link whose valid bit is clear.

A lookup walks the chain one slot per clock until it finds a slot that matches both the process ID and the page number, or until the chain ends. It then returns hit or miss, the frame, and the number of slots it visited. A maintenance port adds a mapping or removes one. An add places the new slot at the head of its chain. A remove walks the chain and unlinks the matching slot, either by rewriting the anchor or by rewriting the link of the slot before it. Only one operation is in progress at a time.

Both the lookup request and the response use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while any operation is in progress, while a response is waiting, and whenever `mnt_valid` is high. The response stays valid with all of its fields unchanged until a clock edge where `rsp_ready` is high. The maintenance port uses the same valid/ready rule and has no response.

Top module: `hipt_engine`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` and `mnt_ready` are 1, and every chain is empty, so any lookup misses after visiting 0 slots.
- R2: The anchor slot for a key is found by splitting the concatenation {pid, vpn}, zero-extended, into 6-bit pieces starting at bit 0 and XOR-ing the pieces together. Keys with equal hashes share one chain, and keys with different hashes never meet.
- R3: A hit requires that both the process ID and the page number of the visited slot equal the key. `rsp_frame` is then the index of that slot. A slot that matches on the page number alone does not hit.
- R4: When the walk reaches the end of the chain with no match, `rsp_hit` is 0 and `rsp_frame` is 0.
- R5: `rsp_visits` is the 1-based position of the matching slot in its chain on a hit, and the full chain length on a miss.
- R6: If a request is taken at clock edge E, `rsp_valid` rises after edge E+p for a hit at position p, or after edge E+L+1 for a miss on a chain of length L. It is low before that.
- R7: An add (`mnt_op`=0) writes the key into slot `mnt_frame` and makes that slot the head of its chain. The newest entry is therefore visited first.
- R8: A remove (`mnt_op`=1) unlinks the matching slot whether it sits at the head, in the middle or at the tail of its chain. All other slots stay reachable in their order. A remove of a key that is not present changes nothing.
- R9: When both ports are valid in the idle state, maintenance wins and `req_ready` is low. A lookup waits until the add or remove has finished.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and all of its fields hold. The cycle after it is taken, `rsp_valid` is 0.
- R11: While a response is pending, neither `req_ready` nor `mnt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_pid | input | PID_W (8) | Process ID of the key |
| req_vpn | input | VPN_W (20) | Virtual page number of the key |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 when the key was found |
| rsp_frame | output | log2(FRAMES) (6) | Frame of the matching slot, 0 on a miss |
| rsp_visits | output | log2(FRAMES+1) (7) | Slots visited by the walk |
| mnt_valid | input | 1 | Maintenance command valid |
| mnt_ready | output | 1 | Maintenance command can be taken |
| mnt_op | input | 1 | 0 = add mapping, 1 = remove mapping |
| mnt_pid | input | PID_W (8) | Process ID of the mapping |
| mnt_vpn | input | VPN_W (20) | Virtual page number of the mapping |
| mnt_frame | input | log2(FRAMES) (6) | Frame to fill on an add; ignored on a remove |

## Verification
Each lookup's response is due a fixed number of edges after the accepting edge: p edges for a hit at chain position p, and L+1 edges for a miss on a chain of length L. The bench works this latency out from its own queue model of the chains. It then samples `rsp_valid` at every falling edge from acceptance on, expecting 0 before the due edge and 1 exactly at it. The hit, frame and visit count are compared at that edge. Held responses are re-checked on each stalled cycle. The gaps that maintenance causes are checked through `req_ready` right after the command is taken.

// File: rtl/hipt_pkg.sv
package hipt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WALK   = 3'd1,
    ST_RESP   = 3'd2,
    ST_INSERT = 3'd3,
    ST_REMOVE = 3'd4
  } eng_state_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_DEL = 1'b1
  } mnt_op_e;

endpackage

// File: rtl/hipt_hash.sv
module hipt_hash #(
  parameter int KEY_W = 28,
  parameter int OUT_W = 6
) (
  input  logic [KEY_W-1:0] key,
  output logic [OUT_W-1:0] slot
);
  localparam int PIECES = (KEY_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W  = PIECES * OUT_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(key);

  always_comb begin
    slot = '0;
    for (int s = 0; s < PIECES; s++) begin
      slot = slot ^ padded[s*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/hipt_anchor_tbl.sv
module hipt_anchor_tbl #(
  parameter int SLOTS = 64,
  parameter int PTR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SLOTS)-1:0] rd_idx,
  output logic                     rd_vld,
  output logic [PTR_W-1:0]         rd_ptr,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_idx,
  input  logic                     wr_vld,
  input  logic [PTR_W-1:0]         wr_ptr
);
  logic             head_vld [SLOTS];
  logic [PTR_W-1:0] head_ptr [SLOTS];

  assign rd_vld = head_vld[rd_idx];
  assign rd_ptr = head_ptr[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        head_vld[i] <= 1'b0;
        head_ptr[i] <= '0;
      end
    end else if (wr_en) begin
      head_vld[wr_idx] <= wr_vld;
      head_ptr[wr_idx] <= wr_ptr;
    end
  end
endmodule

// File: rtl/hipt_frame_tbl.sv
module hipt_frame_tbl #(
  parameter int FRAMES = 64,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(FRAMES)-1:0] rd_idx,
  output logic [PID_W-1:0]          rd_pid,
  output logic [VPN_W-1:0]          rd_vpn,
  output logic                      rd_nvld,
  output logic [$clog2(FRAMES)-1:0] rd_nptr,
  input  logic                      fill_en,
  input  logic [$clog2(FRAMES)-1:0] fill_idx,
  input  logic [PID_W-1:0]          fill_pid,
  input  logic [VPN_W-1:0]          fill_vpn,
  input  logic                      fill_nvld,
  input  logic [$clog2(FRAMES)-1:0] fill_nptr,
  input  logic                      link_en,
  input  logic [$clog2(FRAMES)-1:0] link_idx,
  input  logic                      link_nvld,
  input  logic [$clog2(FRAMES)-1:0] link_nptr
);
  localparam int FW = $clog2(FRAMES);

  logic [PID_W-1:0] own_pid  [FRAMES];
  logic [VPN_W-1:0] own_vpn  [FRAMES];
  logic             nxt_vld  [FRAMES];
  logic [FW-1:0]    nxt_ptr  [FRAMES];

  assign rd_pid  = own_pid[rd_idx];
  assign rd_vpn  = own_vpn[rd_idx];
  assign rd_nvld = nxt_vld[rd_idx];
  assign rd_nptr = nxt_ptr[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAMES; i++) begin
        own_pid[i] <= '0;
        own_vpn[i] <= '0;
        nxt_vld[i] <= 1'b0;
        nxt_ptr[i] <= '0;
      end
    end else if (fill_en) begin
      own_pid[fill_idx] <= fill_pid;
      own_vpn[fill_idx] <= fill_vpn;
      nxt_vld[fill_idx] <= fill_nvld;
      nxt_ptr[fill_idx] <= fill_nptr;
    end else if (link_en) begin
      nxt_vld[link_idx] <= link_nvld;
      nxt_ptr[link_idx] <= link_nptr;
    end
  end
endmodule

// File: rtl/hipt_engine.sv
module hipt_engine
  import hipt_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PID_W-1:0]            req_pid,
  input  logic [VPN_W-1:0]            req_vpn,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_hit,
  output logic [$clog2(FRAMES)-1:0]   rsp_frame,
  output logic [$clog2(FRAMES+1)-1:0] rsp_visits,
  input  logic                        mnt_valid,
  output logic                        mnt_ready,
  input  logic                        mnt_op,
  input  logic [PID_W-1:0]            mnt_pid,
  input  logic [VPN_W-1:0]            mnt_vpn,
  input  logic [$clog2(FRAMES)-1:0]   mnt_frame
);
  localparam int FW    = $clog2(FRAMES);
  localparam int CNT_W = $clog2(FRAMES+1);
  localparam int KEY_W = PID_W + VPN_W;

  eng_state_e state_q;

  logic [PID_W-1:0] key_pid_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic [FW-1:0]    slot_q;
  logic [FW-1:0]    add_frame_q;
  logic             cur_vld_q;
  logic [FW-1:0]    cur_q;
  logic             prev_vld_q;
  logic [FW-1:0]    prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit_q;
  logic [FW-1:0]    frame_q;
  logic [CNT_W-1:0] visits_q;

  logic             idle;
  logic             mnt_go;
  logic             req_go;
  logic [KEY_W-1:0] sel_key;
  logic [FW-1:0]    new_slot;

  logic [FW-1:0]    anc_rd_idx;
  logic             anc_rd_vld;
  logic [FW-1:0]    anc_rd_ptr;
  logic             anc_wr_en;
  logic             anc_wr_vld;
  logic [FW-1:0]    anc_wr_ptr;

  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;
  logic             ent_nvld;
  logic [FW-1:0]    ent_nptr;
  logic             fill_en;
  logic             link_en;
  logic             match;

  // handshake
  assign idle      = (state_q == ST_IDLE);
  assign mnt_ready = idle;
  assign req_ready = idle && !mnt_valid;
  assign mnt_go    = mnt_valid && idle;
  assign req_go    = req_valid && req_ready;

  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_hit    = hit_q;
  assign rsp_frame  = frame_q;
  assign rsp_visits = visits_q;

  // hash of the key being accepted this cycle
  assign sel_key = mnt_valid ? {mnt_pid, mnt_vpn} : {req_pid, req_vpn};

  hipt_hash #(.KEY_W(KEY_W), .OUT_W(FW)) u_hash (
    .key  (sel_key),
    .slot (new_slot)
  );

  assign anc_rd_idx = idle ? new_slot : slot_q;

  hipt_anchor_tbl #(.SLOTS(FRAMES), .PTR_W(FW)) u_anchor (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (anc_rd_idx),
    .rd_vld (anc_rd_vld),
    .rd_ptr (anc_rd_ptr),
    .wr_en  (anc_wr_en),
    .wr_idx (slot_q),
    .wr_vld (anc_wr_vld),
    .wr_ptr (anc_wr_ptr)
  );

  hipt_frame_tbl #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_frames (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (cur_q),
    .rd_pid    (ent_pid),
    .rd_vpn    (ent_vpn),
    .rd_nvld   (ent_nvld),
    .rd_nptr   (ent_nptr),
    .fill_en   (fill_en),
    .fill_idx  (add_frame_q),
    .fill_pid  (key_pid_q),
    .fill_vpn  (key_vpn_q),
    .fill_nvld (anc_rd_vld),
    .fill_nptr (anc_rd_ptr),
    .link_en   (link_en),
    .link_idx  (prev_q),
    .link_nvld (ent_nvld),
    .link_nptr (ent_nptr)
  );

  // a visited slot matches only on both key halves
  assign match = cur_vld_q && (ent_pid == key_pid_q) && (ent_vpn == key_vpn_q);

  // table writes: add writes both tables, remove rewrites exactly one link
  always_comb begin
    fill_en    = (state_q == ST_INSERT);
    link_en    = (state_q == ST_REMOVE) && match && prev_vld_q;
    anc_wr_en  = fill_en || ((state_q == ST_REMOVE) && match && !prev_vld_q);
    anc_wr_vld = fill_en ? 1'b1 : ent_nvld;
    anc_wr_ptr = fill_en ? add_frame_q : ent_nptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      key_pid_q   <= '0;
      key_vpn_q   <= '0;
      slot_q      <= '0;
      add_frame_q <= '0;
      cur_vld_q   <= 1'b0;
      cur_q       <= '0;
      prev_vld_q  <= 1'b0;
      prev_q      <= '0;
      cnt_q       <= '0;
      hit_q       <= 1'b0;
      frame_q     <= '0;
      visits_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (mnt_go) begin
            key_pid_q   <= mnt_pid;
            key_vpn_q   <= mnt_vpn;
            slot_q      <= new_slot;
            add_frame_q <= mnt_frame;
            cur_vld_q   <= anc_rd_vld;
            cur_q       <= anc_rd_ptr;
            prev_vld_q  <= 1'b0;
            state_q     <= (mnt_op == OP_ADD) ? ST_INSERT : ST_REMOVE;
          end else if (req_go) begin
            key_pid_q <= req_pid;
            key_vpn_q <= req_vpn;
            slot_q    <= new_slot;
            cur_vld_q <= anc_rd_vld;
            cur_q     <= anc_rd_ptr;
            cnt_q     <= '0;
            state_q   <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (!cur_vld_q) begin
            hit_q    <= 1'b0;
            frame_q  <= '0;
            visits_q <= cnt_q;
            state_q  <= ST_RESP;
          end else if (match) begin
            hit_q    <= 1'b1;
            frame_q  <= cur_q;
            visits_q <= cnt_q + CNT_W'(1);
            state_q  <= ST_RESP;
          end else begin
            cnt_q     <= cnt_q + CNT_W'(1);
            cur_vld_q <= ent_nvld;
            cur_q     <= ent_nptr;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        ST_INSERT: begin
          state_q <= ST_IDLE;
        end
        ST_REMOVE: begin
          if (!cur_vld_q || match) begin
            state_q <= ST_IDLE;
          end else begin
            prev_vld_q <= 1'b1;
            prev_q     <= cur_q;
            cur_vld_q  <= ent_nvld;
            cur_q      <= ent_nptr;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hipt_engine_chk.sv
module hipt_engine_chk #(
  parameter int FRAMES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic                        rsp_hit,
  input logic [$clog2(FRAMES)-1:0]   rsp_frame,
  input logic [$clog2(FRAMES+1)-1:0] rsp_visits,
  input logic                        mnt_valid,
  input logic                        mnt_ready
);
  localparam int CNT_W = $clog2(FRAMES+1);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_frame) && $stable(rsp_visits)));

  p_rsp_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

  p_mnt_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_valid && mnt_ready) |=> (!rsp_valid && !req_ready));

  p_walk_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid);

  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !mnt_ready));

  p_miss_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0));

  p_hit_visits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((!rsp_hit || rsp_visits != '0) && rsp_visits <= CNT_W'(FRAMES)));
endmodule

bind hipt_engine hipt_engine_chk #(.FRAMES(FRAMES)) u_chk (.*);

// File: tb/hipt_engine_tb_top.sv
module hipt_engine_tb_top;
  localparam int FRAMES = 64;
  localparam int PID_W  = 8;
  localparam int VPN_W  = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b0;
  logic             rsp_hit;
  logic [5:0]       rsp_frame;
  logic [6:0]       rsp_visits;
  logic             mnt_valid = 1'b0;
  logic             mnt_ready;
  logic             mnt_op = 1'b0;
  logic [PID_W-1:0] mnt_pid = '0;
  logic [VPN_W-1:0] mnt_vpn = '0;
  logic [5:0]       mnt_frame = '0;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  // behavioural model: per-slot chains, newest first
  int m_pid [FRAMES];
  int m_vpn [FRAMES];
  int chain [FRAMES][$];

  always #2.5 clk = ~clk;

  hipt_engine #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) dut_i (.*);

  function automatic int hash_of(input int pid, input int vpn);
    logic [29:0] k;
    int h;
    k = {2'b00, 8'(pid), 20'(vpn)};
    h = 0;
    for (int s = 0; s < 5; s++) h = h ^ int'(k[s*6 +: 6]);
    return h;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; mnt_valid = 1'b0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < FRAMES; i++) chain[i].delete();
    @(negedge clk);
  endtask

  task automatic do_mnt(input bit op, input int pid, input int vpn, input int frame);
    int h;
    mnt_valid = 1'b1; mnt_op = op; mnt_pid = 8'(pid); mnt_vpn = 20'(vpn); mnt_frame = 6'(frame);
    #1;
    while (mnt_ready !== 1'b1) begin @(negedge clk); #1; end
    @(negedge clk);
    mnt_valid = 1'b0;
    h = hash_of(pid, vpn);
    if (!op) begin
      m_pid[frame] = pid; m_vpn[frame] = vpn;
      chain[h].push_front(frame);
    end else begin
      for (int i = 0; i < chain[h].size(); i++) begin
        if (m_pid[chain[h][i]] == pid && m_vpn[chain[h][i]] == vpn) begin
          chain[h].delete(i);
          break;
        end
      end
    end
  endtask

  task automatic do_lookup(input int pid, input int vpn, input int hold, input string tag);
    int h, vis, frame, lat;
    bit hit;
    h = hash_of(pid, vpn);
    hit = 1'b0; frame = 0; vis = 0;
    for (int i = 0; i < chain[h].size(); i++) begin
      vis++;
      if (m_pid[chain[h][i]] == pid && m_vpn[chain[h][i]] == vpn) begin
        hit = 1'b1; frame = chain[h][i];
        break;
      end
    end
    lat = hit ? vis : vis + 1;
    req_valid = 1'b1; req_pid = 8'(pid); req_vpn = 20'(vpn); rsp_ready = 1'b0;
    #1;
    while (req_ready !== 1'b1) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 0; j < lat; j++) begin
      chk({tag, " R6"}, "rsp_valid early", int'(rsp_valid), 0);
      @(negedge clk);
    end
    chk({tag, " R6"}, "rsp_valid due", int'(rsp_valid), 1);
    chk({tag, hit ? " R3" : " R4"}, "rsp_hit", int'(rsp_hit), int'(hit));
    chk({tag, hit ? " R3" : " R4"}, "rsp_frame", int'(rsp_frame), frame);
    chk({tag, " R5"}, "rsp_visits", int'(rsp_visits), vis);
    chk({tag, " R11"}, "ready while pending", int'(req_ready | mnt_ready), 0);
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      chk({tag, " R10"}, "held valid", int'(rsp_valid), 1);
      chk({tag, " R10"}, "held frame", int'(rsp_frame), frame);
      chk({tag, " R10"}, "held visits", int'(rsp_visits), vis);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R10"}, "valid after take", int'(rsp_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "mnt_ready", int'(mnt_ready), 1);
    do_lookup(0, 4, 0, "R1");

    // R2/R7 three colliding keys in one chain, newest first
    chk("R2", "model hash collide", int'(hash_of(1, 0) == 4 && hash_of(0, 'h100) == 4 && hash_of(8'h41, 4) == 4), 1);
    do_mnt(1'b0, 0, 4, 10);
    do_mnt(1'b0, 1, 0, 20);
    do_mnt(1'b0, 0, 'h100, 30);
    do_lookup(0, 'h100, 0, "R7");
    do_lookup(1, 0, 0, "R2");
    do_lookup(0, 4, 0, "R3");
    do_lookup(8'h41, 4, 0, "R3 pid");
    do_lookup(0, 5, 0, "R2 other slot");

    // R10 back-pressure
    do_lookup(1, 0, 3, "R10");

    // R8 remove middle, head, absent, tail
    do_mnt(1'b1, 1, 0, 0);
    do_lookup(1, 0, 0, "R8 mid");
    do_lookup(0, 4, 0, "R8 mid");
    do_mnt(1'b1, 0, 'h100, 0);
    do_lookup(0, 4, 0, "R8 head");
    do_mnt(1'b1, 7, 7, 0);
    do_lookup(0, 4, 0, "R8 absent");
    do_mnt(1'b1, 0, 4, 0);
    do_lookup(0, 4, 0, "R8 tail");

    // spread keys over several slots
    for (int i = 0; i < 8; i++) do_mnt(1'b0, i * 37 + 3, i * 1111 + 9, i);
    for (int i = 0; i < 8; i++) do_lookup(i * 37 + 3, i * 1111 + 9, i % 2, "R3 spread");
    do_lookup(3, 9 + 1, 0, "R4 spread");

    // R9 maintenance wins over a lookup offered in the same cycle
    mnt_valid = 1'b1; mnt_op = 1'b0; mnt_pid = 8'd5; mnt_vpn = 20'h777; mnt_frame = 6'd40;
    req_valid = 1'b1; req_pid = 8'd5; req_vpn = 20'h777;
    #1;
    chk("R9", "req_ready both valid", int'(req_ready), 0);
    chk("R9", "mnt_ready both valid", int'(mnt_ready), 1);
    @(negedge clk);
    mnt_valid = 1'b0;
    m_pid[40] = 5; m_vpn[40] = 'h777;
    chain[hash_of(5, 'h777)].push_front(40);
    #1;
    chk("R9", "req_ready during add", int'(req_ready), 0);
    do_lookup(5, 'h777, 0, "R9");

    // long chain: every frame in slot 0
    do_reset();
    for (int i = 0; i < FRAMES; i++) do_mnt(1'b0, 0, i | (i << 6), i);
    do_lookup(0, 0, 0, "R5 deepest");
    do_lookup(0, 63 | (63 << 6), 0, "R7 newest");
    do_lookup(0, 'h41000, 0, "R6 full miss");

    // R1 reset empties the table
    do_reset();
    do_lookup(0, 5 | (5 << 6), 0, "R1 cleared");

    finish_run();
  end
endmodule